// File: doc/BRIEF.md
# Latency Register Calibration Sequencer

This block works out the transmit and receive path latencies of a serial link and loads them into the timestamp correction registers of a MAC. A single-cycle start pulse launches a fixed sequence on a simple register master port. The block first reads two raw delay words. Each word is an unsigned fixed-point count of sampling-clock cycles with eight fractional bits. It then converts each word into a signed 16.16 nanosecond value and adds a fixed serializer offset for that direction. Finally it writes each 32-bit result as two 16-bit halves.

The sampling clock period is 4.375 ns and one unit interval is 0.8 ns. The transmit offset is +225 UI (180 ns) and the receive offset is -45 UI (-36 ns). In 16.16 units one raw LSB is exactly 1120, so the conversion is plain integer arithmetic. A busy flag covers the sequence. A done flag is raised after the last write and is held until the next start pulse. Both converted values stay visible on output ports.

The bus master raises a request with address, write enable and write data, and holds all of them until the slave answers with an acknowledge. The acknowledge may come after any number of cycles.

Top module: `lat_cal_seq`

## Requirements
- R1: After reset, busy, done and bus_req are 0, and tx_lat and rx_lat are 0.
- R2: A start pulse makes the block read address 0xE2 (transmit raw word) and then address 0xE3 (receive raw word), with bus_we at 0. Only bits [20:0] of each read word are used: bits [20:8] are the integer sampling cycles and bits [7:0] are the fraction. Bits [31:21] have no effect.
- R3: While bus_req is 1 and bus_ack is 0, bus_req, bus_addr, bus_we and bus_wdata hold their values. Each access completes in the cycle that bus_ack is 1, for any acknowledge delay.
- R4: tx_lat equals raw_tx*1120 + 11796480, truncated to 32 bits. A raw word of 0x27F4 (39.953125 cycles) gives 0x0162CB80.
- R5: rx_lat equals raw_rx*1120 - 2359296 in 32-bit two's complement. A raw word of 0 gives 0xFFDC0000.
- R6: After the reads, exactly four writes follow in this order, each carrying the half in bits [15:0] with bits [31:16] zero: tx_lat[15:0] to 0xD1, tx_lat[31:16] to 0xD2, rx_lat[15:0] to 0xD4, then rx_lat[31:16] to 0xD5.
- R7: busy is 1 from the cycle after start until the last write is acknowledged. done then becomes 1 and stays 1 until the next start. busy and done are never 1 together.
- R8: A start pulse while busy is 1 has no effect: no extra bus access occurs and the running sequence finishes unchanged.
- R9: tx_lat and rx_lat keep their values after completion and change only when a new sequence computes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle sequence start pulse |
| bus_req | output | 1 | Register access strobe |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, held until next start |
| tx_lat | output | 32 | Transmit latency, 16.16 ns |
| rx_lat | output | 32 | Receive latency, 16.16 ns, two's complement |

## Verification
The assertions check on every cycle that a pending request holds steady until acknowledged, that busy and done never coincide, that done rises only just after the acknowledged write to 0xD5, that a read targets only the two raw-word addresses, and that a start pulse from done launches a new sequence. Only the bench scenarios can show the arithmetic and the exact order and contents of the six accesses. These cover the 0x27F4 word, a zero receive word that yields a negative value, the largest raw words, ignored upper read bits, long acknowledge delays and a start pulse that arrives mid-sequence.

// File: rtl/lat_cal_seq.sv
module lat_cal_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RAW_W = 21,
  parameter int HALF_W = 16,
  parameter int SCALE = 1120,
  parameter int TX_OFS = 11796480,
  parameter int RX_OFS = -2359296,
  parameter logic [ADDR_W-1:0] TX_RAW_ADDR = 8'hE2,
  parameter logic [ADDR_W-1:0] RX_RAW_ADDR = 8'hE3,
  parameter logic [ADDR_W-1:0] TX_FRAC_ADDR = 8'hD1,
  parameter logic [ADDR_W-1:0] TX_INT_ADDR = 8'hD2,
  parameter logic [ADDR_W-1:0] RX_FRAC_ADDR = 8'hD4,
  parameter logic [ADDR_W-1:0] RX_INT_ADDR = 8'hD5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] tx_lat,
  output logic [DATA_W-1:0] rx_lat
);

  localparam int ACC_W = RAW_W + 13;
  localparam int PAD_W = DATA_W - HALF_W;
  localparam logic signed [ACC_W-1:0] SCALE_S = ACC_W'(SCALE);
  localparam logic signed [ACC_W-1:0] TX_OFS_S = ACC_W'(TX_OFS);
  localparam logic signed [ACC_W-1:0] RX_OFS_S = ACC_W'(RX_OFS);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_TX, S_RD_RX, S_CALC, S_WR0, S_WR1, S_WR2, S_WR3, S_DONE
  } state_t;

  state_t state, state_nxt;
  logic [RAW_W-1:0] tx_raw, rx_raw;
  logic signed [ACC_W-1:0] tx_ext, rx_ext;
  logic [DATA_W-1:0] tx_calc, rx_calc;

  assign tx_ext = $signed({{(ACC_W-RAW_W){1'b0}}, tx_raw});
  assign rx_ext = $signed({{(ACC_W-RAW_W){1'b0}}, rx_raw});
  assign tx_calc = DATA_W'(tx_ext * SCALE_S + TX_OFS_S);
  assign rx_calc = DATA_W'(rx_ext * SCALE_S + RX_OFS_S);

  assign busy = (state != S_IDLE) && (state != S_DONE);
  assign done = (state == S_DONE);

  always_comb begin
    bus_req = 1'b1;
    bus_we = 1'b1;
    bus_addr = '0;
    bus_wdata = '0;
    case (state)
      S_RD_TX: begin bus_we = 1'b0; bus_addr = TX_RAW_ADDR; end
      S_RD_RX: begin bus_we = 1'b0; bus_addr = RX_RAW_ADDR; end
      S_WR0: begin bus_addr = TX_FRAC_ADDR; bus_wdata = {{PAD_W{1'b0}}, tx_lat[HALF_W-1:0]}; end
      S_WR1: begin bus_addr = TX_INT_ADDR; bus_wdata = {{PAD_W{1'b0}}, tx_lat[DATA_W-1:HALF_W]}; end
      S_WR2: begin bus_addr = RX_FRAC_ADDR; bus_wdata = {{PAD_W{1'b0}}, rx_lat[HALF_W-1:0]}; end
      S_WR3: begin bus_addr = RX_INT_ADDR; bus_wdata = {{PAD_W{1'b0}}, rx_lat[DATA_W-1:HALF_W]}; end
      default: begin bus_req = 1'b0; bus_we = 1'b0; end
    endcase
  end

  always_comb begin
    state_nxt = state;
    case (state)
      S_IDLE, S_DONE: if (start) state_nxt = S_RD_TX;
      S_RD_TX: if (bus_ack) state_nxt = S_RD_RX;
      S_RD_RX: if (bus_ack) state_nxt = S_CALC;
      S_CALC: state_nxt = S_WR0;
      S_WR0: if (bus_ack) state_nxt = S_WR1;
      S_WR1: if (bus_ack) state_nxt = S_WR2;
      S_WR2: if (bus_ack) state_nxt = S_WR3;
      S_WR3: if (bus_ack) state_nxt = S_DONE;
      default: state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tx_raw <= '0;
      rx_raw <= '0;
      tx_lat <= '0;
      rx_lat <= '0;
    end else begin
      state <= state_nxt;
      if (state == S_RD_TX && bus_ack) tx_raw <= bus_rdata[RAW_W-1:0];
      if (state == S_RD_RX && bus_ack) rx_raw <= bus_rdata[RAW_W-1:0];
      if (state == S_CALC) begin
        tx_lat <= tx_calc;
        rx_lat <= rx_calc;
      end
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_req && bus_ack && bus_we && bus_addr == RX_INT_ADDR));

  // R2
  read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> bus_addr == TX_RAW_ADDR || bus_addr == RX_RAW_ADDR);

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> busy && bus_req && !bus_we && bus_addr == TX_RAW_ADDR);

  // R9
  lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(tx_lat) && $stable(rx_lat));

endmodule

// File: tb/lat_cal_seq_bench.sv
module lat_cal_seq_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic bus_req, bus_we, bus_ack, busy, done;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, tx_lat, rx_lat;

  int checks = 0;
  int errors = 0;
  int ack_delay = 0;
  int wait_cnt = 0;
  logic [31:0] regs [256];
  int nlog = 0;
  logic [7:0] log_addr [16];
  logic log_we [16];
  logic [31:0] log_data [16];

  always #2 clk = ~clk;

  lat_cal_seq u_lat_cal_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .busy(busy), .done(done), .tx_lat(tx_lat), .rx_lat(rx_lat));

  initial begin
    bus_ack = 0;
    bus_rdata = 0;
    for (int i = 0; i < 256; i++) regs[i] = 0;
  end

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack <= 0;
      wait_cnt <= 0;
    end else if (bus_req) begin
      if (wait_cnt >= ack_delay) begin
        bus_ack <= 1;
        bus_rdata <= regs[bus_addr];
        if (bus_we) regs[bus_addr] <= bus_wdata;
        if (nlog < 16) begin
          log_addr[nlog] <= bus_addr;
          log_we[nlog] <= bus_we;
          log_data[nlog] <= bus_wdata;
        end
        nlog <= nlog + 1;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_tx(logic [20:0] raw);
    longint v = longint'(raw) * 1120 + 180 * 65536;
    return v[31:0];
  endfunction

  function automatic logic [31:0] exp_rx(logic [20:0] raw);
    longint v = longint'(raw) * 1120 - 36 * 65536;
    return v[31:0];
  endfunction

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic run_seq(string tag, logic [31:0] txw, logic [31:0] rxw, int dly);
    logic [31:0] et, er;
    ack_delay = dly;
    regs[8'hE2] = txw;
    regs[8'hE3] = rxw;
    nlog = 0;
    et = exp_tx(txw[20:0]);
    er = exp_rx(rxw[20:0]);
    pulse_start();
    check({tag, " R7 busy"}, busy, 1);
    wait_done();
    repeat (2) @(negedge clk);
    check({tag, " R7 done"}, {done, busy}, 2'b10);
    check({tag, " R4 tx_lat"}, tx_lat, et);
    check({tag, " R5 rx_lat"}, rx_lat, er);
    check({tag, " R2 R6 count"}, nlog, 6);
    check({tag, " R2 rd tx"}, {log_addr[0], log_we[0]}, {8'hE2, 1'b0});
    check({tag, " R2 rd rx"}, {log_addr[1], log_we[1]}, {8'hE3, 1'b0});
    check({tag, " R6 wr0"}, {log_addr[2], log_we[2], log_data[2]}, {8'hD1, 1'b1, 16'h0, et[15:0]});
    check({tag, " R6 wr1"}, {log_addr[3], log_we[3], log_data[3]}, {8'hD2, 1'b1, 16'h0, et[31:16]});
    check({tag, " R6 wr2"}, {log_addr[4], log_we[4], log_data[4]}, {8'hD4, 1'b1, 16'h0, er[15:0]});
    check({tag, " R6 wr3"}, {log_addr[5], log_we[5], log_data[5]}, {8'hD5, 1'b1, 16'h0, er[31:16]});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset flags", {busy, done, bus_req}, 3'b000);
    check("R1 reset lat", {tx_lat, rx_lat}, 64'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle", {busy, done, bus_req}, 3'b000);
  endtask

  task automatic t_example();
    run_seq("ex", 32'h27F4, 32'h27F4, 0);
    check("R4 0x27F4 const", tx_lat, 32'h0162CB80);
  endtask

  task automatic t_negative();
    run_seq("neg", 32'h100, 32'h0, 1);
    check("R5 zero rx const", rx_lat, 32'hFFDC0000);
  endtask

  task automatic t_max_upper();
    run_seq("max", 32'hFFFF_FFFF, 32'hFFE0_0000, 2);
    check("R2 upper ignored", rx_lat, 32'hFFDC0000);
  endtask

  task automatic t_long_delay();
    run_seq("slow", 32'h1_2345, 32'h0_8A1C, 9);
  endtask

  task automatic t_busy_start();
    ack_delay = 3;
    regs[8'hE2] = 32'h0ABC;
    regs[8'hE3] = 32'h0DEF;
    nlog = 0;
    pulse_start();
    repeat (4) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_done();
    repeat (3) @(negedge clk);
    check("R8 access count", nlog, 6);
    check("R8 tx_lat", tx_lat, exp_tx(21'h0ABC));
    check("R8 rx_lat", rx_lat, exp_rx(21'h0DEF));
  endtask

  task automatic t_hold();
    logic [31:0] t0, r0;
    t0 = tx_lat;
    r0 = rx_lat;
    regs[8'hE2] = 32'h5;
    repeat (20) @(negedge clk);
    check("R9 tx hold", tx_lat, t0);
    check("R9 rx hold", rx_lat, r0);
    check("R7 done hold", {done, bus_req}, 2'b10);
  endtask

  task automatic finish_all();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_all();
  end

  initial begin
    t_reset();
    t_example();
    t_negative();
    t_max_upper();
    t_long_delay();
    t_busy_start();
    t_hold();
    finish_all();
  end
endmodule